// File: doc/BRIEF.md
# Sensor Register Command Port over SPI

This block is the serial register front end of a sensor die. An external master selects it with an active-low chip select and clocks in one 16-bit command per select window. The three most significant bits name the command, the next five bits name a register, and the low byte carries write data. The block keeps a small register file made of a few read-only identification bytes and one writable control byte. It carries out the command when the select window closes. It then prepares a 16-bit answer that the master collects during its next select window.

The serial pins are oversampled on the block's own clock, so SCLK must run several times slower than `clk`. The master drives MOSI and samples MISO on the rising edge of SCLK. The block shifts MISO on the falling edge, most significant bit first. Outside a select window MISO is not driven, which is signalled through `miso_oe`. A frame whose rising SCLK edge count is not exactly 16 is thrown away. So is any command that arrives while the oscillator is reported faulty, or any command that is neither a valid read nor a write to the control byte. In each of these cases the next answer is an error frame that carries one flag for each cause.

Top module: `spi_sensor_regif`

## Requirements
- R1: Opcode 3'b010 in bits 15:13 with bits 12:8 equal to the control address (default 5'h12) is a write: the control byte takes bits 7:0 of the frame, masked, when the frame closes.
- R2: Only bit 3 (filter bypass) and bits 1:0 (self-test) of the control byte can hold a 1. All other bits always read 0, whatever data is written.
- R3: A write (opcode 3'b010) to any address other than the control address leaves every register unchanged and yields an error answer with the request flag (bit 8) set.
- R4: Opcode 3'b100 is a read. The answer has bits 15:14 = 2'b10, the address echoed in bits 12:8 and the register contents in bits 7:0. The frame's low byte has no effect.
- R5: The answer to an accepted write has bits 15:14 = 2'b01, the address in bits 12:8 and the new control byte in bits 7:0.
- R6: Every opcode other than 3'b010 and 3'b100 yields an error answer with the request flag set and changes no state.
- R7: A frame that closes after any number of rising SCLK edges other than 16 is discarded. The next answer is an error frame with the serial-error flag (bit 9) set.
- R8: If `osc_fault` is high when a frame closes, the command is not carried out and the answer is an error frame with the oscillator flag (bit 10) set.
- R9: Bit 13 of every answer makes the count of ones over all 16 answer bits odd.
- R10: The answer prepared from one frame is shifted out MSB first during the next select window. MISO changes after falling SCLK edges and is valid at rising edges.
- R11: `miso_oe` is high inside a select window and low once chip select is high.
- R12: After reset the control byte is 0 and the first answer is 16'h2000.
- R13: Addresses 0 to 3 read as constant identification bytes 8'hA0 plus the address. Any other address except the control address reads as 0.

An error answer has bits 15:14 = 2'b11, flags in bits 10:8 (oscillator, serial, request), bits 12:11 = 0 and low byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select framing one command |
| mosi | input | 1 | Serial command data, sampled on rising SCLK |
| osc_fault | input | 1 | Oscillator fault flag, checked when a frame closes |
| miso | output | 1 | Serial answer data, MSB first |
| miso_oe | output | 1 | High while MISO should be driven |
| ctrl_reg | output | 8 | Current control byte to the sensor core |

## Verification
The checker watches these properties on every cycle: the control byte never holds a bit outside its mask, and it changes only in the cycle after a frame closes cleanly with no oscillator fault. The prepared answer always has odd parity. A miscounted frame or an oscillator fault always turns the next answer into an error frame with the right flag. The output enable falls once chip select has been seen high. Only the bench's sweeps can show the rest: the decoded address and data of each command, the ID and unmapped read values, and the serial order of the bits on MISO. They also show that a rejected write truly leaves the control byte as it was. The bench compares every answer the master collects with a model built from the requirements.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  // Command opcodes carried in the top three frame bits
  localparam logic [2:0] OPC_WRITE = 3'b010;
  localparam logic [2:0] OPC_READ  = 3'b100;

  // Answer kinds carried in the top two answer bits
  typedef enum logic [1:0] {
    ANS_IDLE  = 2'b00,
    ANS_WRITE = 2'b01,
    ANS_READ  = 2'b10,
    ANS_ERROR = 2'b11
  } ans_kind_e;

  typedef struct packed {
    logic osc;
    logic ser;
    logic req;
  } err_flags_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_active,
  output logic cs_start,
  output logic cs_end,
  output logic mosi_s
);

  logic [STAGES-1:0] sclk_sq, cs_sq, mosi_sq;
  logic [STAGES-1:0] sclk_sd, cs_sd, mosi_sd;
  logic              sclk_prev_q, cs_prev_q;
  logic              sclk_s, cs_s;

  // Next-state of the synchroniser chains
  always_comb begin
    sclk_sd = {sclk_sq[STAGES-2:0], sclk};
    cs_sd   = {cs_sq[STAGES-2:0],   cs_n};
    mosi_sd = {mosi_sq[STAGES-2:0], mosi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sq     <= '0;
      cs_sq       <= '1;
      mosi_sq     <= '0;
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      sclk_sq     <= sclk_sd;
      cs_sq       <= cs_sd;
      mosi_sq     <= mosi_sd;
      sclk_prev_q <= sclk_s;
      cs_prev_q   <= cs_s;
    end
  end

  assign sclk_s    = sclk_sq[STAGES-1];
  assign cs_s      = cs_sq[STAGES-1];
  assign mosi_s    = mosi_sq[STAGES-1];

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
  assign cs_active = ~cs_s;
  assign cs_start  = ~cs_s & cs_prev_q;
  assign cs_end    = cs_s & ~cs_prev_q;

endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_rise,
  input  logic                  sclk_fall,
  input  logic                  cs_active,
  input  logic                  cs_start,
  input  logic                  cs_end,
  input  logic                  mosi_s,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  frame_ok,
  output logic                  frame_bad,
  output logic                  miso,
  output logic                  miso_oe
);

  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int CNT_MAX = FRAME_BITS + 1;

  logic [FRAME_BITS-1:0] rx_q, rx_d, tx_q, tx_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  oe_q, oe_d;
  logic                  ok_q, ok_d, bad_q, bad_d;
  logic                  rx_en, tx_en, cnt_en, oe_en;
  logic                  take_bit, push_bit;

  assign take_bit = sclk_rise & cs_active;
  assign push_bit = sclk_fall & cs_active & (cnt_q != '0);

  always_comb begin
    rx_en  = take_bit;
    rx_d   = {rx_q[FRAME_BITS-2:0], mosi_s};

    tx_en  = cs_start | push_bit;
    tx_d   = cs_start ? tx_word : {tx_q[FRAME_BITS-2:0], 1'b0};

    cnt_en = cs_start | take_bit;
    if (cs_start)                          cnt_d = '0;
    else if (cnt_q != CNT_W'(CNT_MAX))     cnt_d = cnt_q + 1'b1;
    else                                   cnt_d = cnt_q;

    oe_en  = cs_start | cs_end;
    oe_d   = cs_start;

    ok_d   = cs_end & (cnt_q == CNT_W'(FRAME_BITS));
    bad_d  = cs_end & (cnt_q != CNT_W'(FRAME_BITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      if (rx_en)  rx_q  <= rx_d;
      if (tx_en)  tx_q  <= tx_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (oe_en)  oe_q  <= oe_d;
      ok_q  <= ok_d;
      bad_q <= bad_d;
    end
  end

  assign rx_word   = rx_q;
  assign frame_ok  = ok_q;
  assign frame_bad = bad_q;
  assign miso      = tx_q[FRAME_BITS-1];
  assign miso_oe   = oe_q;

endmodule

// File: rtl/reg_cmd_exec.sv
module reg_cmd_exec
  import spi_regif_pkg::*;
#(
  parameter int                ADDR_W    = 5,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h12,
  parameter logic [DATA_W-1:0] CTRL_MASK = 8'h0B,
  parameter int                NUM_ID    = 4,
  parameter logic [DATA_W-1:0] ID_BASE   = 8'hA0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_ok,
  input  logic                       frame_bad,
  input  logic [3+ADDR_W+DATA_W-1:0] rx_word,
  input  logic                       osc_fault,
  output logic [3+ADDR_W+DATA_W-1:0] resp_word,
  output logic [DATA_W-1:0]          ctrl_q
);

  localparam int FB      = 3 + ADDR_W + DATA_W;
  localparam int PAR_BIT = FB - 3;

  function automatic logic [FB-1:0] seal(input logic [FB-1:0] w);
    logic [FB-1:0] r;
    r          = w;
    r[PAR_BIT] = 1'b0;
    r[PAR_BIT] = ~(^r);
    return r;
  endfunction

  function automatic logic [FB-1:0] err_word(input err_flags_t f);
    return seal({ANS_ERROR, 1'b0, {(ADDR_W-3){1'b0}}, f, {DATA_W{1'b0}}});
  endfunction

  localparam logic [FB-1:0] RESP_RST = {1'b0, 1'b0, 1'b1, {(FB-3){1'b0}}};

  logic [2:0]        opc;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              is_wr, is_rd, req_err;
  logic [DATA_W-1:0] id_val [NUM_ID];
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] ctrl_d;
  logic [FB-1:0]     resp_q, resp_d;
  logic              ctrl_en, resp_en;
  err_flags_t        flags;

  // Read-only identification bytes
  for (genvar g = 0; g < NUM_ID; g++) begin : g_id
    assign id_val[g] = ID_BASE + DATA_W'(g);
  end

  assign opc   = rx_word[FB-1 -: 3];
  assign addr  = rx_word[FB-4 -: ADDR_W];
  assign wdata = rx_word[DATA_W-1:0];

  always_comb begin
    is_wr   = (opc == OPC_WRITE);
    is_rd   = (opc == OPC_READ);
    req_err = !(is_rd || (is_wr && addr == CTRL_ADDR));

    rd_val = '0;
    for (int i = 0; i < NUM_ID; i++) begin
      if (addr == ADDR_W'(i)) rd_val = id_val[i];
    end
    if (addr == CTRL_ADDR) rd_val = ctrl_q;
  end

  // Next-state: command execution and answer building
  always_comb begin
    ctrl_en = 1'b0;
    ctrl_d  = ctrl_q;
    resp_en = 1'b0;
    resp_d  = resp_q;
    flags   = '{osc: osc_fault, ser: 1'b0, req: 1'b0};
    if (frame_bad) begin
      flags.ser = 1'b1;
      resp_en   = 1'b1;
      resp_d    = err_word(flags);
    end else if (frame_ok) begin
      resp_en = 1'b1;
      if (osc_fault || req_err) begin
        flags.req = req_err;
        resp_d    = err_word(flags);
      end else if (is_wr) begin
        ctrl_en = 1'b1;
        ctrl_d  = wdata & CTRL_MASK;
        resp_d  = seal({ANS_WRITE, 1'b0, addr, wdata & CTRL_MASK});
      end else begin
        resp_d  = seal({ANS_READ, 1'b0, addr, rd_val});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      resp_q <= RESP_RST;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (resp_en) resp_q <= resp_d;
    end
  end

  assign resp_word = resp_q;

endmodule

// File: rtl/spi_sensor_regif.sv
module spi_sensor_regif #(
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 5,
  parameter int          DATA_W      = 8,
  parameter logic [4:0]  CTRL_ADDR   = 5'h12,
  parameter logic [7:0]  CTRL_MASK   = 8'h0B,
  parameter int          NUM_ID      = 4,
  parameter logic [7:0]  ID_BASE     = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              osc_fault,
  output logic              miso,
  output logic              miso_oe,
  output logic [DATA_W-1:0] ctrl_reg
);

  localparam int FB = 3 + ADDR_W + DATA_W;

  logic [1:0]    rst_pipe_q;
  logic          rst_n_int;
  logic          sclk_rise, sclk_fall, cs_active, cs_start, cs_end, mosi_s;
  logic [FB-1:0] rx_word, resp_word;
  logic          frame_ok, frame_bad;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_active (cs_active),
    .cs_start  (cs_start),
    .cs_end    (cs_end),
    .mosi_s    (mosi_s)
  );

  spi_frame_shift #(.FRAME_BITS(FB)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_active (cs_active),
    .cs_start  (cs_start),
    .cs_end    (cs_end),
    .mosi_s    (mosi_s),
    .tx_word   (resp_word),
    .rx_word   (rx_word),
    .frame_ok  (frame_ok),
    .frame_bad (frame_bad),
    .miso      (miso),
    .miso_oe   (miso_oe)
  );

  reg_cmd_exec #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (ADDR_W'(CTRL_ADDR)),
    .CTRL_MASK (DATA_W'(CTRL_MASK)),
    .NUM_ID    (NUM_ID),
    .ID_BASE   (DATA_W'(ID_BASE))
  ) u_exec (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .frame_ok  (frame_ok),
    .frame_bad (frame_bad),
    .rx_word   (rx_word),
    .osc_fault (osc_fault),
    .resp_word (resp_word),
    .ctrl_q    (ctrl_reg)
  );

endmodule

// File: rtl/spi_sensor_regif_chk.sv
module spi_sensor_regif_chk #(
  parameter int         FB        = 16,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] CTRL_MASK = 8'h0B
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              cs_active,
  input logic              miso_oe,
  input logic [DATA_W-1:0] ctrl_reg,
  input logic [FB-1:0]     resp_word,
  input logic              frame_ok,
  input logic              frame_bad,
  input logic              osc_fault
);

  // R2: masked-out control bits never hold a one
  p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ctrl_reg & ~DATA_W'(CTRL_MASK)) == '0);

  // R3, R8: control byte moves only after a clean frame without fault
  p_ctrl_guard_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$stable(ctrl_reg) |-> ($past(frame_ok) && !$past(osc_fault)));

  // R9: prepared answer always has odd parity
  p_odd_parity_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    ^resp_word == 1'b1);

  // R7: miscounted frame turns the next answer into a serial error
  p_bad_frame_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    frame_bad |=> (resp_word[FB-1 -: 2] == 2'b11) && resp_word[DATA_W+1]);

  // R7: a frame cannot close both cleanly and badly
  p_close_excl_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(frame_ok && frame_bad));

  // R8: oscillator fault at close gives an error answer with its flag
  p_osc_fault_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (frame_ok && osc_fault) |=> (resp_word[FB-1 -: 2] == 2'b11) && resp_word[DATA_W+2]);

  // R11: output enable drops once chip select is seen high
  p_oe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cs_active |=> !miso_oe);

endmodule

bind spi_sensor_regif spi_sensor_regif_chk #(
  .FB        (FB),
  .DATA_W    (DATA_W),
  .CTRL_MASK (CTRL_MASK)
) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .cs_active (cs_active),
  .miso_oe   (miso_oe),
  .ctrl_reg  (ctrl_reg),
  .resp_word (resp_word),
  .frame_ok  (frame_ok),
  .frame_bad (frame_bad),
  .osc_fault (osc_fault)
);

// File: tb/spi_sensor_regif_bench.sv
`timescale 1ns/1ps
module spi_sensor_regif_bench;

  localparam logic [4:0] CTRL = 5'h12;
  localparam int         WD_CYCLES = 190000;

  logic       clk, rst_n, sclk, cs_n, mosi, osc_fault;
  logic       miso, miso_oe;
  logic [7:0] ctrl_reg;

  int         n_checks = 0;
  int         n_fail   = 0;
  logic [15:0] exp_next;
  logic [7:0]  model_ctrl;
  logic        oe_mid, oe_after;

  spi_sensor_regif u_spi_sensor_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .osc_fault (osc_fault),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .ctrl_reg  (ctrl_reg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [1:0] kind, input logic [4:0] f,
                                     input logic [7:0] d);
    logic [15:0] w;
    int ones;
    w = {kind, 1'b0, f, d};
    ones = 0;
    for (int i = 0; i < 16; i++) ones += w[i];
    w[13] = (ones % 2 == 0);
    return w;
  endfunction

  function automatic logic [7:0] rd_model(input logic [4:0] a);
    if (a == CTRL) return model_ctrl;
    if (a < 5'd4)  return 8'hA0 + {3'b000, a};
    return 8'h00;
  endfunction

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx   = '0;
    cs_n = 1'b0;
    tick(6);
    oe_mid = miso_oe;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[15 - (i % 16)];
      tick(4);
      rx = {rx[14:0], miso};
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    tick(8);
    oe_after = miso_oe;
  endtask

  // Runs one frame, checks the answer collected against the model, updates model
  task automatic cmd(input logic [15:0] tx, input int nbits, input logic osc,
                     input string req);
    logic [15:0] rx;
    logic [2:0]  op;
    logic [4:0]  a;
    logic        wr, rd, rq;
    int          ones;
    osc_fault = osc;
    xfer(tx, nbits, rx);
    if (nbits == 16) begin
      chk({req, " R10 answer"}, rx, exp_next);
      ones = 0;
      for (int i = 0; i < 16; i++) ones += rx[i];
      chk("R9 odd parity", 16'(ones % 2), 16'd1);
    end
    op = tx[15:13];
    a  = tx[12:8];
    wr = (op == 3'b010);
    rd = (op == 3'b100);
    rq = !((wr && a == CTRL) || rd);
    if (nbits != 16)      exp_next = mk(2'b11, {2'b00, osc, 1'b1, 1'b0}, 8'h00);
    else if (osc || rq)   exp_next = mk(2'b11, {2'b00, osc, 1'b0, rq}, 8'h00);
    else if (wr) begin
      model_ctrl = tx[7:0] & 8'h0B;
      exp_next   = mk(2'b01, a, model_ctrl);
    end else              exp_next = mk(2'b10, a, rd_model(a));
    osc_fault = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; osc_fault = 1'b0;
    model_ctrl = 8'h00;
    exp_next   = 16'h2000;
    oe_mid = 1'b0; oe_after = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R12 reset state
    chk("R12 ctrl after reset", {8'h00, ctrl_reg}, 16'h0000);
    chk("R11 oe after reset", {15'd0, miso_oe}, 16'd0);

    // R13 R4 read sweep over all addresses, low byte varied (ignored)
    for (int a = 0; a < 32; a++) begin
      cmd({3'b100, 5'(a), 8'(a * 37 + 5)}, 16, 1'b0, "R4 R13 read");
    end
    chk("R11 oe inside window", {15'd0, oe_mid}, 16'd1);
    chk("R11 oe after window", {15'd0, oe_after}, 16'd0);

    // R1 R3 R5 write sweep over all addresses
    for (int a = 0; a < 32; a++) begin
      cmd({3'b010, 5'(a), 8'hFF ^ 8'(a)}, 16, 1'b0, "R1 R3 R5 write");
      chk("R1 R3 ctrl after write", {8'h00, ctrl_reg}, {8'h00, model_ctrl});
    end

    // R2 every data value into the control byte, then read it back
    for (int d = 0; d < 256; d++) begin
      cmd({3'b010, CTRL, 8'(d)}, 16, 1'b0, "R2 ctrl data sweep");
      chk("R2 ctrl masked", {8'h00, ctrl_reg}, {8'h00, 8'(d) & 8'h0B});
    end
    cmd({3'b100, CTRL, 8'h00}, 16, 1'b0, "R4 ctrl readback");

    // R6 all opcodes at the control address
    for (int o = 0; o < 8; o++) begin
      cmd({3'(o), CTRL, 8'h0A}, 16, 1'b0, "R6 opcode sweep");
      chk("R6 ctrl state", {8'h00, ctrl_reg}, {8'h00, model_ctrl});
    end

    // R7 miscounted frames carrying a write are discarded
    cmd({3'b010, CTRL, 8'h01}, 16, 1'b0, "R7 setup");
    cmd({3'b010, CTRL, 8'h08}, 0,  1'b0, "R7 zero edges");
    cmd({3'b100, 5'd1, 8'h00}, 16, 1'b0, "R7 after zero-edge frame");
    cmd({3'b010, CTRL, 8'h08}, 15, 1'b0, "R7 short frame");
    cmd({3'b100, 5'd2, 8'h00}, 16, 1'b0, "R7 after short frame");
    cmd({3'b010, CTRL, 8'h08}, 17, 1'b0, "R7 long frame");
    chk("R7 ctrl untouched", {8'h00, ctrl_reg}, 16'h0001);
    cmd({3'b010, CTRL, 8'h02}, 1,  1'b1, "R7 R8 one-edge frame with fault");
    cmd({3'b100, CTRL, 8'h00}, 16, 1'b0, "R7 R8 after combined error");

    // R8 oscillator fault blocks a valid write and a read
    cmd({3'b010, CTRL, 8'h0B}, 16, 1'b1, "R8 write under fault");
    chk("R8 ctrl untouched", {8'h00, ctrl_reg}, 16'h0001);
    cmd({3'b100, 5'd0, 8'h00}, 16, 1'b1, "R8 read under fault");
    cmd({3'b001, 5'd3, 8'h00}, 16, 1'b1, "R8 R6 bad opcode under fault");
    cmd({3'b100, CTRL, 8'h00}, 16, 1'b0, "R8 final");
    cmd({3'b100, 5'd0, 8'h00}, 16, 1'b0, "R10 flush");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule